// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block watches the receive byte stream of an Ethernet MAC after the preamble and start delimiter have been stripped. Each byte arrives with a valid strobe. Start-of-frame and end-of-frame markers are qualified by that valid strobe. The block collects the six destination address bytes and counts the frame length. It also picks out the type, opcode and quanta fields that a flow-control frame carries.

One cycle after the last byte of a frame, the block gives a single-cycle result. The result holds an accept or reject decision, a long-frame flag, a miss flag and an oversize interrupt pulse. When flow control is enabled and the frame is a PAUSE frame, a quanta strobe goes out with the result.

The configuration inputs are the length limit, broadcast reject, promiscuous mode, flow-control enable and the station address. The block copies them into internal registers only while it is disabled. A frame in progress when enable drops is abandoned and gives no result.

Top module: `rx_accept_filter`

## Requirements
- R1: For a frame whose last byte is taken on clock edge k, `res_valid` is high for exactly the cycle after edge k. The frame length is the number of valid bytes from the start-of-frame byte through the end-of-frame byte, both included. While `res_valid` is low, every result and strobe output is low.
- R2: `res_long` and a one-cycle `babble_irq` are raised with the result when the length is strictly greater than the latched limit. A frame of exactly the limit raises neither.
- R3: The latched length limit resets to 1518 and keeps that value when the block is enabled straight out of reset.
- R4: The first destination byte on the wire is compared with `cfg_station_addr[47:40]` and the sixth with `[7:0]`. Outside promiscuous mode, a frame addressed to the station is accepted with miss clear.
- R5: Outside promiscuous mode, a destination that is neither the station address nor a permitted broadcast is rejected.
- R6: A destination of all ones is a broadcast. With broadcast reject clear, a broadcast is accepted with miss clear.
- R7: With broadcast reject set and promiscuous clear, a broadcast is rejected.
- R8: With broadcast reject and promiscuous both set, a broadcast is accepted with miss set.
- R9: In promiscuous mode every frame is accepted. Miss is set exactly when the frame would have been refused outside promiscuous mode.
- R10: With flow control enabled, a frame of at least 18 bytes is a PAUSE frame when its destination is 01:80:C2:00:00:01, its bytes 12-13 are 0x8808 and its bytes 14-15 are 0x0001. For such a frame, `pause_valid` pulses with the result and `pause_quanta` carries bytes 16-17, first byte high. With flow control disabled or a different opcode, there is no pulse.
- R11: Configuration inputs changed while `enable` is high have no effect until `enable` has been low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; configuration is copied while low |
| cfg_max_len | input | 11 | Length limit in bytes |
| cfg_bc_reject | input | 1 | Refuse broadcast destinations |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_fc_enable | input | 1 | Enable PAUSE frame detection |
| cfg_station_addr | input | 48 | Station unicast address, first wire byte in [47:40] |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| res_valid | output | 1 | Result strobe |
| res_accept | output | 1 | Frame accepted |
| res_long | output | 1 | Frame longer than the limit |
| res_miss | output | 1 | Accepted only because of promiscuous mode |
| babble_irq | output | 1 | Oversize interrupt pulse |
| pause_valid | output | 1 | PAUSE frame detected |
| pause_quanta | output | 16 | Pause time from the PAUSE frame |

## Verification
The bench sends frames addressed to the station, to broadcast, to the PAUSE multicast address and to random addresses. It repeats them across all four combinations of broadcast reject and promiscuous mode. This separates an address match from a broadcast pass and from a promiscuous-only accept, which only the miss flag reveals.

Frame lengths are placed at the limit, one byte either side of it, and well below it, so an off-by-one in the length count is caught. PAUSE frames are sent both with flow control on and off, and with a wrong opcode. A configuration change while enabled is followed by frames sent before and after re-enabling, which shows when the settings take effect.

// File: rtl/rxf_pkg.sv
// Shared definitions for the receive acceptance filter.
// Assumes standard 48-bit MAC addresses and an 11-bit length limit.
package rxf_pkg;
    localparam int LEN_W  = 11;
    localparam int ADDR_W = 48;
    localparam int HDR_W  = 48;  // type, opcode and quanta, 16 bits each

    localparam logic [ADDR_W-1:0] BCAST_DA   = 48'hFFFF_FFFF_FFFF;
    localparam logic [ADDR_W-1:0] PAUSE_DA   = 48'h0180_C200_0001;
    localparam logic [15:0]       PAUSE_TYPE = 16'h8808;
    localparam logic [15:0]       PAUSE_OPC  = 16'h0001;

    typedef struct packed {
        logic [LEN_W-1:0]  max_len;
        logic              bc_reject;
        logic              promisc;
        logic              fc_en;
        logic [ADDR_W-1:0] station;
    } cfg_t;
endpackage

// File: rtl/rxf_cfg_hold.sv
// Configuration holding register.
// Copies the configuration inputs every cycle while the block is disabled
// and freezes them while it is enabled.
// Assumes the caller provides the reset value of the length limit.
module rxf_cfg_hold
    import rxf_pkg::*;
#(
    parameter int MAX_LEN_RST = 1518
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);
    // Reload on every disabled cycle; hold while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.max_len   <= LEN_W'(MAX_LEN_RST);
            cfg_q.bc_reject <= 1'b0;
            cfg_q.promisc   <= 1'b0;
            cfg_q.fc_en     <= 1'b0;
            cfg_q.station   <= '0;
        end else if (!enable) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/rxf_frame_track.sv
// Frame tracker.
// Counts frame bytes, with saturation, and captures the destination address
// and the type, opcode and quanta fields (bytes 12 to 17).
// Pulses done in the cycle after the end-of-frame byte is taken.
// Assumes the markers are qualified by rx_valid. A frame in progress is
// dropped when enable falls.
module rxf_frame_track
    import rxf_pkg::*;
#(
    parameter int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              done,
    output logic [CNT_W-1:0]  len_q,
    output logic [ADDR_W-1:0] da_q,
    output logic [HDR_W-1:0]  hdr_q
);
    localparam int DA_BYTES = ADDR_W / 8;
    localparam int HDR_LO   = 12;
    localparam int HDR_HI   = HDR_LO + HDR_W / 8;

    logic             in_frame;
    logic             take;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] nxt_len;

    // Decide whether this byte belongs to a frame, and where it sits.
    always_comb begin
        take    = enable && rx_valid && (rx_sof || in_frame);
        idx     = rx_sof ? '0 : len_q;
        nxt_len = rx_sof ? CNT_W'(1)
                : ((&len_q) ? len_q : len_q + CNT_W'(1));
    end

    // Track the frame and shift in the address and header fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            done     <= 1'b0;
            len_q    <= '0;
            da_q     <= '0;
            hdr_q    <= '0;
        end else begin
            done <= take && rx_eof;
            if (!enable) begin
                in_frame <= 1'b0;
            end else if (take) begin
                in_frame <= !rx_eof;
                len_q    <= nxt_len;
                if (idx < CNT_W'(DA_BYTES))
                    da_q <= {(rx_sof ? '0 : da_q[ADDR_W-9:0]), rx_data};
                if (rx_sof)
                    hdr_q <= '0;
                else if (idx >= CNT_W'(HDR_LO) && idx < CNT_W'(HDR_HI))
                    hdr_q <= {hdr_q[HDR_W-9:0], rx_data};
            end
        end
    end
endmodule

// File: rtl/rxf_decide.sv
// Acceptance decision, combinational.
// Sets accept, miss, long and pause detection from the captured fields and
// the latched configuration. Assumes its inputs are stable while done is high.
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int CNT_W = LEN_W + 1
) (
    input  cfg_t              cfg,
    input  logic [CNT_W-1:0]  len,
    input  logic [ADDR_W-1:0] da,
    input  logic [HDR_W-1:0]  hdr,
    output logic              accept,
    output logic              miss,
    output logic              is_long,
    output logic              pause_hit,
    output logic [15:0]       quanta
);
    localparam int PAUSE_MIN = 18;

    logic bcast;
    logic pass;

    // Check the address, apply the filter modes and compare the length.
    always_comb begin
        bcast     = (da == BCAST_DA);
        pass      = ((da == cfg.station) && !bcast) || (bcast && !cfg.bc_reject);
        accept    = cfg.promisc || pass;
        miss      = cfg.promisc && !pass;
        is_long   = len > CNT_W'(cfg.max_len);
        pause_hit = cfg.fc_en && (da == PAUSE_DA)
                  && (hdr[47:32] == PAUSE_TYPE) && (hdr[31:16] == PAUSE_OPC)
                  && (len >= CNT_W'(PAUSE_MIN));
        quanta    = hdr[15:0];
    end
endmodule

// File: rtl/rx_accept_filter.sv
// Top of the Ethernet receive acceptance filter.
// Combines the configuration register, the frame tracker and the decision
// logic. All results appear for one cycle after the end-of-frame byte.
// Assumes preamble and start delimiter are already removed from the stream.
module rx_accept_filter
    import rxf_pkg::*;
#(
    parameter int MAX_LEN_RST = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic              cfg_bc_reject,
    input  logic              cfg_promisc,
    input  logic              cfg_fc_enable,
    input  logic [ADDR_W-1:0] cfg_station_addr,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_long,
    output logic              res_miss,
    output logic              babble_irq,
    output logic              pause_valid,
    output logic [15:0]       pause_quanta
);
    localparam int CNT_W = LEN_W + 1;

    cfg_t              cfg_in;
    cfg_t              cfg_q;
    logic              done;
    logic [CNT_W-1:0]  len_q;
    logic [ADDR_W-1:0] da_q;
    logic [HDR_W-1:0]  hdr_q;
    logic              d_accept, d_miss, d_long, d_pause;
    logic [15:0]       d_quanta;

    // Pack the configuration inputs.
    always_comb begin
        cfg_in.max_len   = cfg_max_len;
        cfg_in.bc_reject = cfg_bc_reject;
        cfg_in.promisc   = cfg_promisc;
        cfg_in.fc_en     = cfg_fc_enable;
        cfg_in.station   = cfg_station_addr;
    end

    rxf_cfg_hold #(.MAX_LEN_RST(MAX_LEN_RST)) cfg_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_in(cfg_in), .cfg_q(cfg_q)
    );

    rxf_frame_track #(.CNT_W(CNT_W)) trk_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .done(done), .len_q(len_q), .da_q(da_q), .hdr_q(hdr_q)
    );

    rxf_decide #(.CNT_W(CNT_W)) dec_i (
        .cfg(cfg_q), .len(len_q), .da(da_q), .hdr(hdr_q),
        .accept(d_accept), .miss(d_miss), .is_long(d_long),
        .pause_hit(d_pause), .quanta(d_quanta)
    );

    // Gate every result with the done strobe.
    always_comb begin
        res_valid    = done;
        res_accept   = done && d_accept;
        res_miss     = done && d_miss;
        res_long     = done && d_long;
        babble_irq   = done && d_long;
        pause_valid  = done && d_pause;
        pause_quanta = (done && d_pause) ? d_quanta : 16'h0;
    end
endmodule

// File: rtl/rxf_checker.sv
// Assertion checker for rx_accept_filter, attached with bind.
module rxf_checker
    import rxf_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic rx_valid,
    input logic rx_eof,
    input logic res_valid,
    input logic res_accept,
    input logic res_long,
    input logic res_miss,
    input logic babble_irq,
    input logic pause_valid,
    input cfg_t cfg_q
);
    assert_result_after_eof_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(enable && rx_valid && rx_eof));

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_accept || res_long || res_miss || babble_irq || pause_valid));

    assert_babble_with_long_R2: assert property (@(posedge clk) disable iff (!rst_n)
        babble_irq |-> (res_valid && res_long));

    // Miss only arises in promiscuous mode, and always with accept (R8).
    assert_miss_promisc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_accept && cfg_q.promisc));

    assert_pause_fc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid |-> (res_valid && cfg_q.fc_en));

    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(cfg_q));
endmodule

bind rx_accept_filter rxf_checker chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_valid(rx_valid), .rx_eof(rx_eof),
    .res_valid(res_valid), .res_accept(res_accept), .res_long(res_long),
    .res_miss(res_miss), .babble_irq(babble_irq), .pause_valid(pause_valid),
    .cfg_q(cfg_q)
);

// File: tb/rx_accept_filter_tb_top.sv
module rx_accept_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [10:0] cfg_max_len = 11'd0;
    logic        cfg_bc_reject = 1'b0, cfg_promisc = 1'b0, cfg_fc_enable = 1'b0;
    logic [47:0] cfg_station_addr = 48'h0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic        res_valid, res_accept, res_long, res_miss, babble_irq, pause_valid;
    logic [15:0] pause_quanta;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Bench view of the configuration that should be latched.
    int          m_max = 1518;
    bit          m_bcrej = 0, m_prom = 0, m_fc = 0;
    logic [47:0] m_sta = 48'h0;

    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] PDA = 48'h0180_C200_0001;

    always #4 clk = ~clk;

    rx_accept_filter dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_max_len(cfg_max_len),
        .cfg_bc_reject(cfg_bc_reject), .cfg_promisc(cfg_promisc),
        .cfg_fc_enable(cfg_fc_enable), .cfg_station_addr(cfg_station_addr),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .res_valid(res_valid), .res_accept(res_accept), .res_long(res_long),
        .res_miss(res_miss), .babble_irq(babble_irq), .pause_valid(pause_valid),
        .pause_quanta(pause_quanta)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit f_pass(input logic [47:0] da);
        return ((da == m_sta) && (da != BC)) || ((da == BC) && !m_bcrej);
    endfunction

    function automatic bit f_accept(input logic [47:0] da);
        return m_prom || f_pass(da);
    endfunction

    function automatic bit f_miss(input logic [47:0] da);
        return m_prom && !f_pass(da);
    endfunction

    function automatic bit f_pause(input logic [47:0] da, input int len,
                                   input logic [15:0] typ, input logic [15:0] op);
        return m_fc && da == PDA && typ == 16'h8808 && op == 16'h0001 && len >= 18;
    endfunction

    function automatic logic [7:0] f_byte(input int i, input logic [47:0] da,
                                          input logic [15:0] typ, input logic [15:0] op,
                                          input logic [15:0] q);
        if (i < 6)       return da[47-8*i -: 8];
        else if (i == 12) return typ[15:8];
        else if (i == 13) return typ[7:0];
        else if (i == 14) return op[15:8];
        else if (i == 15) return op[7:0];
        else if (i == 16) return q[15:8];
        else if (i == 17) return q[7:0];
        else              return 8'($urandom);
    endfunction

    // Apply a configuration with a disable/enable cycle.
    task automatic set_cfg(input int mx, input bit bcr, input bit pr, input bit fc,
                           input logic [47:0] sta);
        @(negedge clk);
        enable = 0;
        cfg_max_len = 11'(mx); cfg_bc_reject = bcr; cfg_promisc = pr;
        cfg_fc_enable = fc; cfg_station_addr = sta;
        @(negedge clk);
        @(negedge clk);
        enable = 1;
        m_max = mx; m_bcrej = bcr; m_prom = pr; m_fc = fc; m_sta = sta;
    endtask

    task automatic send(input string req, input logic [47:0] da, input int len,
                        input logic [15:0] typ, input logic [15:0] op, input logic [15:0] q);
        bit ep;
        ep = f_pause(da, len, typ, op);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = f_byte(i, da, typ, op, q);
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        chk(res_valid == 1, req, "res_valid", res_valid, 1);
        chk(res_accept == f_accept(da), req, "accept", res_accept, f_accept(da));
        chk(res_miss == f_miss(da), req, "miss", res_miss, f_miss(da));
        chk(res_long == (len > m_max), req, "long", res_long, len > m_max);
        chk(babble_irq == (len > m_max), req, "babble", babble_irq, len > m_max);
        chk(pause_valid == ep, req, "pause_valid", pause_valid, ep);
        if (ep) chk(pause_quanta == q, req, "quanta", pause_quanta, q);
        @(negedge clk);
        chk(res_valid == 0 && babble_irq == 0, req, "strobe width", res_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] sta;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(res_valid == 0 && babble_irq == 0 && pause_valid == 0, "R1", "reset outputs",
            res_valid, 0);
        rst_n = 1;
        // R3: enabled straight from reset, the limit is 1518 despite port value 0.
        send("R3", BC, 1518, 16'h0800, 16'h0, 16'h0);
        send("R3", BC, 1519, 16'h0800, 16'h0, 16'h0);

        sta = 48'h02AB_CD12_3456;
        // R2: limit boundary with a short limit.
        set_cfg(64, 0, 0, 0, sta);
        send("R2", sta, 64, 16'h0800, 0, 0);
        send("R2", sta, 65, 16'h0800, 0, 0);
        send("R2", sta, 63, 16'h0800, 0, 0);
        // R4, R5, R6
        send("R4", sta, 70, 16'h0800, 0, 0);
        send("R5", sta ^ 48'h0100_0000_0000, 70, 16'h0800, 0, 0);
        send("R5", sta ^ 48'h0000_0000_0001, 70, 16'h0800, 0, 0);
        send("R6", BC, 60, 16'h0800, 0, 0);
        // R7
        set_cfg(1518, 1, 0, 0, sta);
        send("R7", BC, 60, 16'h0800, 0, 0);
        // R8
        set_cfg(1518, 1, 1, 0, sta);
        send("R8", BC, 60, 16'h0800, 0, 0);
        // R9
        set_cfg(1518, 0, 1, 0, sta);
        send("R9", 48'h1234_5678_9ABC, 60, 16'h0800, 0, 0);
        send("R9", sta, 60, 16'h0800, 0, 0);
        send("R9", BC, 60, 16'h0800, 0, 0);
        // R10
        set_cfg(1518, 0, 0, 1, sta);
        send("R10", PDA, 64, 16'h8808, 16'h0001, 16'hBEEF);
        send("R10", PDA, 64, 16'h8808, 16'h0002, 16'h1234);
        send("R10", PDA, 18, 16'h8808, 16'h0001, 16'h00FF);
        set_cfg(1518, 0, 0, 0, sta);
        send("R10", PDA, 64, 16'h8808, 16'h0001, 16'hBEEF);
        // R11: change ports while enabled; the old settings must hold.
        @(negedge clk);
        cfg_bc_reject = 1; cfg_max_len = 11'd40;
        send("R11", BC, 60, 16'h0800, 0, 0);
        set_cfg(40, 1, 0, 0, sta);
        send("R11", BC, 60, 16'h0800, 0, 0);

        // Random mix of configurations and frames.
        for (int n = 0; n < 40; n++) begin
            if (n % 5 == 0)
                set_cfg(64 + int'($urandom % 1400), 1'($urandom), 1'($urandom),
                        1'($urandom), {8'($urandom) & 8'hFE, 40'($urandom)});
            begin
                logic [47:0] da;
                int len, k;
                logic [15:0] op;
                k = int'($urandom % 4);
                da = (k == 0) ? m_sta : (k == 1) ? BC : (k == 2) ? PDA
                   : {16'($urandom), 32'($urandom)};
                len = ($urandom % 2 == 1) ? m_max - 2 + int'($urandom % 5)
                                          : 18 + int'($urandom % 100);
                op = ($urandom % 4 == 0) ? 16'h0002 : 16'h0001;
                send("R9", da, len, (k == 2) ? 16'h8808 : 16'h0800, op, 16'($urandom));
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule